// File: doc/BRIEF.md
# BCD Calendar Timekeeper Core

This core keeps wall-clock time and a calendar for a low-power timekeeping device. A free-running enable at 32768 Hz feeds an internal prescaler. Each whole second, the core advances eight BCD fields: seconds, minutes, hours, day of month, month, two-digit year, weekday and week number. The calendar applies month lengths and leap years by itself. It steps the weekday and the week number, and it restarts the week count at each new year.

A register port connects the core to whatever access front end the system uses. An access is a span of cycles with `acc_i` held high. The core copies all fields into a snapshot on the first cycle of an access, so a multi-byte read always sees one consistent instant. A one-second step that falls inside an access is held back and applied as soon as the access ends. The host therefore never sees a busy state and never collides with an update. A control byte at address 0 holds a write lock for the time fields and two test bits. The test bits either speed the clock up or switch it into a no-carry increment mode.

Top module: `rtc_core`

## Requirements
- R1: After reset, the fields read as second 0x00, minute 0x00, hour 0x00, day 0x01, month 0x01, year 0x00, weekday 0x01 and week 0x01, and the control byte reads 0x00. The fields sit at address 2 (second), 3 (minute), 4 (hour), 5 (day), 6 (month), 7 (year), 8 (weekday) and 9 (week), each holding two BCD digits.
- R2: `rdata_o` updates one cycle after each access cycle and holds while no access is in progress. In the first cycle of an access it returns the live value. In every later cycle of that access, a field address returns the snapshot taken at the start of the access. Address 0 returns the control byte. Every other address returns 0x00.
- R3: In normal mode (control bits 2 and 3 clear), one second passes every 2^PRESCALE_W enables. Seconds carry into minutes at 59, minutes carry into hours at 59, and hours roll over to a new day at 23.
- R4: The day rolls over after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. In month 02 it rolls over after 29 when the BCD year is divisible by 4, and after 28 otherwise. Month 12 rolls over to month 01 and advances the year, which wraps from 99 to 00.
- R5: Each new day advances the weekday from 1 through 7 and back to 1. When the weekday wraps from 7, the week number advances, wrapping from 53 to 01. A new year sets the week number to 01.
- R6: With control bit 2 set, one second passes every 2^(PRESCALE_W-FAST_SHIFT) enables, which is 32 times faster by default.
- R7: With control bit 3 set, each tick increments all eight fields at once with no carry between them. Seconds and minutes wrap at 59, hours at 23, day at the current month's length, month at 12, year at 99, weekday at 7 and week at 53.
- R8: With control bits 2 and 3 both set, the no-carry increments of R7 happen at the rate of R6.
- R9: The control byte changes only when address 0 is written. Test operation therefore persists until software writes both test bits to zero.
- R10: While control bit 0 (lock) is set, writes to addresses 2 to 9 leave the fields unchanged. Address 0 stays writable.
- R11: A tick that arrives while an access is in progress leaves the fields unchanged until the access ends. The held tick is then applied exactly once, on the first cycle with `acc_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en32k_i | input | 1 | One-cycle enable at the 32768 Hz rate |
| acc_i | input | 1 | High for every cycle of a host access |
| wr_i | input | 1 | Write strobe, valid while `acc_i` is high |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A read result is due one clock after the cycle that presents the address. The bench drives inputs on the falling edge and samples `rdata_o` at the next falling edge. A second-step lands two clocks after the enable that completes the prescaler count: one clock registers the tick and one clock applies it. If that step is held back by an access, it lands one clock after `acc_i` drops. The bench therefore leaves three idle clocks after each enable burst before it reads, and it sizes every burst to whole seconds so that the prescaler phase stays known. A behavioural model advances on every clock, and its predicted read value is compared with `rdata_o` at every falling edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] week;
    logic [7:0] wday;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t RTC_RST_TIME = '{week: 8'h01, wday: 8'h01, yr: 8'h00,
                                         mon: 8'h01, day: 8'h01, hr: 8'h00,
                                         min: 8'h00, sec: 8'h00};

  localparam int CTRL_LOCK_BIT = 0;
  localparam int CTRL_FAST_BIT = 2;
  localparam int CTRL_PAR_BIT  = 3;

  // one BCD step; values at or above the limit restart from the floor
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] lim,
                                          input logic [7:0] floor_v);
    if (v >= lim)               return floor_v;
    else if (v[3:0] >= 4'd9)    return {v[7:4] + 4'd1, 4'h0};
    else                        return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic leap;
    leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                 : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_tickgen.sv
module rtc_tickgen #(
  parameter int PRESCALE_W = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic fast_i,
  output logic tick_o
);
  localparam int SLOW_W = PRESCALE_W - FAST_SHIFT;

  logic [PRESCALE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= en_i && (fast_i ? (&cnt_q[SLOW_W-1:0]) : (&cnt_q));
      if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  rtc_time_t cur_i,
  input  logic      par_i,
  output rtc_time_t nxt_o
);
  logic [7:0] mlen;
  logic       day_end;
  logic       wk_wrap;

  always_comb begin
    mlen    = month_len(cur_i.mon, cur_i.yr);
    day_end = cur_i.day >= mlen;
    wk_wrap = cur_i.wday >= 8'h07;
    nxt_o   = cur_i;
    if (par_i) begin
      nxt_o.sec  = bcd_step(cur_i.sec,  8'h59, 8'h00);
      nxt_o.min  = bcd_step(cur_i.min,  8'h59, 8'h00);
      nxt_o.hr   = bcd_step(cur_i.hr,   8'h23, 8'h00);
      nxt_o.day  = bcd_step(cur_i.day,  mlen,  8'h01);
      nxt_o.mon  = bcd_step(cur_i.mon,  8'h12, 8'h01);
      nxt_o.yr   = bcd_step(cur_i.yr,   8'h99, 8'h00);
      nxt_o.wday = bcd_step(cur_i.wday, 8'h07, 8'h01);
      nxt_o.week = bcd_step(cur_i.week, 8'h53, 8'h01);
    end else begin
      nxt_o.sec = bcd_step(cur_i.sec, 8'h59, 8'h00);
      if (cur_i.sec >= 8'h59) begin
        nxt_o.min = bcd_step(cur_i.min, 8'h59, 8'h00);
        if (cur_i.min >= 8'h59) begin
          nxt_o.hr = bcd_step(cur_i.hr, 8'h23, 8'h00);
          if (cur_i.hr >= 8'h23) begin
            nxt_o.wday = bcd_step(cur_i.wday, 8'h07, 8'h01);
            if (wk_wrap) nxt_o.week = bcd_step(cur_i.week, 8'h53, 8'h01);
            nxt_o.day = bcd_step(cur_i.day, mlen, 8'h01);
            if (day_end) begin
              nxt_o.mon = bcd_step(cur_i.mon, 8'h12, 8'h01);
              if (cur_i.mon >= 8'h12) begin
                nxt_o.yr   = bcd_step(cur_i.yr, 8'h99, 8'h00);
                nxt_o.week = 8'h01;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE_W = 15,
  parameter int FAST_SHIFT = 5,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en32k_i,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FIRST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LAST  = ADDR_W'(9);

  logic [7:0] ctrl_q;
  rtc_time_t  live_q, snap_q, cal_nxt, rd_src;
  logic       acc_q, pend_q, tick;
  logic       acc_rise, in_field, apply;
  logic [2:0] fidx;
  logic [5:0] fbit;
  logic [7:0] rbyte;

  rtc_tickgen #(.PRESCALE_W(PRESCALE_W), .FAST_SHIFT(FAST_SHIFT)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .en_i  (en32k_i),
    .fast_i(ctrl_q[CTRL_FAST_BIT]),
    .tick_o(tick)
  );

  rtc_calendar u_cal (
    .cur_i(live_q),
    .par_i(ctrl_q[CTRL_PAR_BIT]),
    .nxt_o(cal_nxt)
  );

  always_comb begin
    acc_rise = acc_i && !acc_q;
    in_field = (addr_i >= A_FIRST) && (addr_i <= A_LAST);
    fidx     = 3'(addr_i - A_FIRST);
    fbit     = {fidx, 3'b000};
    rd_src   = acc_rise ? live_q : snap_q;
    if (addr_i == A_CTRL) rbyte = ctrl_q;
    else if (in_field)    rbyte = rd_src[fbit +: 8];
    else                  rbyte = 8'h00;
    apply    = !acc_i && (tick || pend_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= 8'h00;
      live_q  <= RTC_RST_TIME;
      snap_q  <= RTC_RST_TIME;
      acc_q   <= 1'b0;
      pend_q  <= 1'b0;
      rdata_o <= 8'h00;
    end else begin
      acc_q  <= acc_i;
      pend_q <= acc_i && (pend_q || tick);
      if (acc_rise) snap_q <= live_q;
      if (acc_i) rdata_o <= rbyte;
      if (acc_i && wr_i && addr_i == A_CTRL) ctrl_q <= wdata_i;
      if (acc_i && wr_i && in_field && !ctrl_q[CTRL_LOCK_BIT])
        live_q[fbit +: 8] <= wdata_i;
      else if (apply)
        live_q <= cal_nxt;
    end
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              acc,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic [7:0]        ctrl,
  input rtc_time_t         live
);
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(rdata));

  p_ctrl_only_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    !(acc && wr && addr == ADDR_W'(0)) |=> $stable(ctrl));

  p_locked_fields_r10: assert property (@(posedge clk) disable iff (rst)
    (acc && wr && ctrl[CTRL_LOCK_BIT]) |=> $stable(live));

  p_no_update_in_read_r11: assert property (@(posedge clk) disable iff (rst)
    (acc && !wr) |=> $stable(live));

  p_hour_range_r3: assert property (@(posedge clk) disable iff (rst)
    live.hr <= 8'h23 && live.min <= 8'h59 && live.sec <= 8'h59);

  p_month_range_r4: assert property (@(posedge clk) disable iff (rst)
    live.mon >= 8'h01 && live.mon <= 8'h12 && live.day >= 8'h01 && live.day <= 8'h31);

  p_week_range_r5: assert property (@(posedge clk) disable iff (rst)
    live.wday >= 8'h01 && live.wday <= 8'h07 && live.week <= 8'h53);
endmodule

bind rtc_core rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .acc  (acc_i),
  .wr   (wr_i),
  .addr (addr_i),
  .rdata(rdata_o),
  .ctrl (ctrl_q),
  .live (live_q)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  localparam int PW = 6;
  localparam int FS = 5;
  localparam int SEC_EN = 2 ** PW;
  localparam int FAST_EN = 2 ** (PW - FS);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0, acc = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  int nchk = 0, nbad = 0, cyc = 0;

  rtc_core #(.PRESCALE_W(PW), .FAST_SHIFT(FS), .ADDR_W(4)) dut_i (
    .clk(clk), .rst(rst), .en32k_i(en), .acc_i(acc), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  logic [7:0] mf [0:15];
  logic [7:0] ms [0:15];
  logic [7:0] mctrl, mrd;
  int         mcnt;
  logic       mtick, mpend, macc, started = 1'b0;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int i);
    return {4'(i / 10), 4'(i % 10)};
  endfunction
  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step(input logic par);
    int s, mi, h, d, mo, y, wd, wk, ml;
    s = b2i(mf[2]); mi = b2i(mf[3]); h = b2i(mf[4]); d = b2i(mf[5]);
    mo = b2i(mf[6]); y = b2i(mf[7]); wd = b2i(mf[8]); wk = b2i(mf[9]);
    ml = mdays(mo, y);
    if (par) begin
      s = (s >= 59) ? 0 : s + 1;   mi = (mi >= 59) ? 0 : mi + 1;
      h = (h >= 23) ? 0 : h + 1;   d = (d >= ml) ? 1 : d + 1;
      mo = (mo >= 12) ? 1 : mo + 1; y = (y >= 99) ? 0 : y + 1;
      wd = (wd >= 7) ? 1 : wd + 1; wk = (wk >= 53) ? 1 : wk + 1;
    end else begin
      s++;
      if (s == 60) begin
        s = 0; mi++;
        if (mi == 60) begin
          mi = 0; h++;
          if (h == 24) begin
            h = 0;
            if (wd >= 7) begin wd = 1; wk = (wk >= 53) ? 1 : wk + 1; end
            else wd++;
            if (d >= ml) begin
              d = 1;
              if (mo >= 12) begin mo = 1; y = (y + 1) % 100; wk = 1; end
              else mo++;
            end else d++;
          end
        end
      end
    end
    mf[2] = i2b(s); mf[3] = i2b(mi); mf[4] = i2b(h); mf[5] = i2b(d);
    mf[6] = i2b(mo); mf[7] = i2b(y); mf[8] = i2b(wd); mf[9] = i2b(wk);
  endtask

  always @(posedge clk) begin
    logic rise, apply, nt;
    if (rst) begin
      for (int i = 0; i < 16; i++) mf[i] = 8'h00;
      mf[5] = 8'h01; mf[6] = 8'h01; mf[8] = 8'h01; mf[9] = 8'h01;
      for (int i = 0; i < 16; i++) ms[i] = mf[i];
      mctrl = 8'h00; mrd = 8'h00; mcnt = 0; mtick = 0; mpend = 0; macc = 0;
    end else begin
      rise = acc && !macc;
      if (acc) begin
        if (addr == 0) mrd = mctrl;
        else if (addr >= 2 && addr <= 9) mrd = rise ? mf[addr] : ms[addr];
        else mrd = 8'h00;
      end
      if (rise) for (int i = 0; i < 16; i++) ms[i] = mf[i];
      apply = (mtick || mpend) && !acc;
      mpend = acc && (mpend || mtick);
      nt = en && (mctrl[2] ? ((mcnt % FAST_EN) == FAST_EN - 1) : (mcnt == SEC_EN - 1));
      if (en) mcnt = (mcnt + 1) % SEC_EN;
      if (acc && wr && addr >= 2 && addr <= 9 && !mctrl[0]) mf[addr] = wdata;
      if (apply) model_step(mctrl[3]);
      if (acc && wr && addr == 0) mctrl = wdata;
      mtick = nt;
      macc = acc;
    end
    started = 1'b1;
    cyc++;
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (started) check("R2 per-clock model", rdata, mrd);

  always @(posedge clk) if (cyc > 50000) begin
    nbad++;
    $display("FAIL watchdog actual=%0d expected=<50000", cyc);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    acc = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); acc = 0; wr = 0;
    @(negedge clk);
  endtask
  task automatic rreg(input logic [3:0] a, output logic [7:0] v);
    acc = 1; wr = 0; addr = a;
    @(negedge clk); v = rdata; acc = 0;
    @(negedge clk);
  endtask
  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] v;
    rreg(a, v);
    check(tag, v, e);
  endtask
  task automatic run(input int n);
    en = 1; repeat (n) @(negedge clk); en = 0;
    idle(3);
  endtask
  task automatic set_all(input logic [7:0] s, mi, h, d, mo, y, wd, wk);
    wreg(2, s); wreg(3, mi); wreg(4, h); wreg(5, d);
    wreg(6, mo); wreg(7, y); wreg(8, wd); wreg(9, wk);
  endtask

  initial begin
    logic [7:0] v;
    idle(3); rst = 0; idle(2);
    // R1 reset values and address map
    expect_reg("R1 sec", 2, 8'h00); expect_reg("R1 min", 3, 8'h00);
    expect_reg("R1 hour", 4, 8'h00); expect_reg("R1 day", 5, 8'h01);
    expect_reg("R1 month", 6, 8'h01); expect_reg("R1 year", 7, 8'h00);
    expect_reg("R1 wday", 8, 8'h01); expect_reg("R1 week", 9, 8'h01);
    expect_reg("R1 ctrl", 0, 8'h00);
    expect_reg("R2 unused addr1", 1, 8'h00);
    expect_reg("R2 unused addr15", 15, 8'h00);
    // R3 R4 R5 leap February, weekday wrap
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h07, 8'h09);
    run(SEC_EN);
    expect_reg("R3 sec wrap", 2, 8'h00); expect_reg("R3 hour wrap", 4, 8'h00);
    expect_reg("R4 leap day 29", 5, 8'h29); expect_reg("R4 month kept", 6, 8'h02);
    expect_reg("R5 wday wrap", 8, 8'h01); expect_reg("R5 week step", 9, 8'h10);
    // R4 non-leap February
    set_all(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h01, 8'h10);
    run(SEC_EN);
    expect_reg("R4 nonleap day", 5, 8'h01); expect_reg("R4 nonleap month", 6, 8'h03);
    // R4 thirty-day month
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h05, 8'h02, 8'h14);
    run(SEC_EN);
    expect_reg("R4 april end", 6, 8'h05); expect_reg("R4 april day", 5, 8'h01);
    // R4 R5 year end
    set_all(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h03, 8'h52);
    run(SEC_EN);
    expect_reg("R4 year wrap", 7, 8'h00); expect_reg("R4 month wrap", 6, 8'h01);
    expect_reg("R5 new year week", 9, 8'h01); expect_reg("R5 wday", 8, 8'h04);
    expect_reg("R3 min carry", 3, 8'h00);
    // R6 fast mode
    wreg(0, 8'h04);
    set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h01);
    run(SEC_EN);
    expect_reg("R6 fast 32 s", 2, 8'h32);
    // R7 parallel no-carry
    wreg(0, 8'h08);
    set_all(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h99, 8'h07, 8'h53);
    run(SEC_EN);
    expect_reg("R7 sec", 2, 8'h00); expect_reg("R7 min", 3, 8'h00);
    expect_reg("R7 hour", 4, 8'h00); expect_reg("R7 day", 5, 8'h01);
    expect_reg("R7 month", 6, 8'h05); expect_reg("R7 year", 7, 8'h00);
    expect_reg("R7 wday", 8, 8'h01); expect_reg("R7 week", 9, 8'h01);
    set_all(8'h05, 8'h10, 8'h11, 8'h15, 8'h06, 8'h45, 8'h03, 8'h20);
    run(SEC_EN);
    expect_reg("R7 sec b", 2, 8'h06); expect_reg("R7 day b", 5, 8'h16);
    expect_reg("R7 week b", 9, 8'h21);
    // R8 parallel and fast
    wreg(0, 8'h0C);
    set_all(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h01);
    run(SEC_EN);
    expect_reg("R8 sec", 2, 8'h32); expect_reg("R8 hour", 4, 8'h08);
    expect_reg("R8 month", 6, 8'h09); expect_reg("R8 wday", 8, 8'h05);
    expect_reg("R8 week", 9, 8'h33); expect_reg("R8 day", 5, mf[5]);
    // R9 test bit persists until written
    wreg(0, 8'h08);
    expect_reg("R9 ctrl", 0, 8'h08);
    run(SEC_EN);
    expect_reg("R9 still parallel min", 3, 8'h33);
    wreg(0, 8'h00);
    expect_reg("R9 ctrl cleared", 0, 8'h00);
    // R10 lock
    wreg(2, 8'h20);
    wreg(0, 8'h01);
    wreg(2, 8'h45);
    expect_reg("R10 locked sec", 2, 8'h20);
    wreg(0, 8'h00);
    expect_reg("R10 ctrl writable", 0, 8'h00);
    wreg(2, 8'h45);
    expect_reg("R10 unlocked sec", 2, 8'h45);
    // R2 snapshot within one access
    acc = 1; wr = 1; addr = 2; wdata = 8'h10;
    @(negedge clk); wr = 0;
    @(negedge clk); check("R2 snapshot", rdata, 8'h45);
    acc = 0; @(negedge clk);
    expect_reg("R2 new access", 2, 8'h10);
    // R11 tick deferred during access
    acc = 1; addr = 2; en = 1;
    repeat (SEC_EN) @(negedge clk);
    en = 0; idle(3);
    check("R11 held during access", rdata, 8'h10);
    acc = 0; @(negedge clk);
    expect_reg("R11 applied after", 2, 8'h11);
    idle(2);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule